// File: doc/BRIEF.md
# Process-Table Root Pointer Cache

This block sits inside a radix address-translation unit. It holds two architectural registers: the base address of the process table and the current process identifier. It also keeps two cached process-table entries. The first is entry 0, which serves addresses in the upper quadrant. The second is the entry indexed by the current process identifier, which serves the lower quadrant. When the page-table walker asks for a root pointer, the block checks the top two address bits. It then returns the cached root or fetches the 16-byte entry from memory. A mismatched pair of top bits is reported as a segment fault. Partition tables and hypervisor state are not modelled.

Register writes and TLB-invalidate operations decide which cached entries stay valid. Every register write also asks both TLBs (data and instruction) to flush. A fetch that is in flight when its slot is invalidated is not trusted: the data that returns is dropped and the entry is fetched again using the updated registers.

The control path is a four-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_REPLY` on a fault or a hit, and to `ST_ISSUE` on a miss.
- `ST_ISSUE` drives the memory read and always moves to `ST_WAIT`.
- `ST_WAIT` waits for the memory response. It moves to `ST_REPLY` with fresh data, or back to `ST_ISSUE` when the fetch went stale.
- `ST_REPLY` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `ptab_root_ctrl`

## Requirements
- R1: After reset the block is ready (`req_ready`=1). `resp_valid`, `mem_rd_valid`, `tlb_flush_d` and `tlb_flush_i` are all 0, and both cached slots are empty, so the first request of each quadrant misses.
- R2: A request whose two address bits `req_hi[1]` and `req_hi[0]` differ gets a response one cycle after acceptance with `resp_fault`=1 and `resp_root`=0. No memory read is issued.
- R3: When `req_hi[1]`=1 the entry-0 slot is used and a miss reads at `base`. When `req_hi[1]`=0 the process-ID slot is used and a miss reads at `base + (pid << 4)`.
- R4: On a miss, a one-cycle `mem_rd_valid` is raised in the cycle after acceptance. The first returned doubleword is stored in the slot and is returned as `resp_root` (`resp_fault`=0) in the cycle after `mem_rsp_valid`.
- R5: A hit responds one cycle after acceptance with the cached root and issues no memory read.
- R6: A register write with `reg_wr_sel`=1 loads the table base and invalidates both slots.
- R7: A register write with `reg_wr_sel`=0 loads the process ID and invalidates only the process-ID slot. The entry-0 slot keeps hitting.
- R8: An invalidate pulse with `inv_ric`=2 invalidates both slots. The values 0, 1 and 3 leave both slots valid and raise no flush.
- R9: Any register write raises `tlb_flush_d` and `tlb_flush_i` together for exactly the one cycle after the write. Invalidate pulses never raise them.
- R10: `req_ready` is high only while idle. A request presented while busy is ignored and produces no response.
- R11: If the slot being fetched is invalidated between the read and its data, the returned data is discarded. A new read is issued using the current registers, and the response carries the refetched entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 1 = table base, 0 = process ID |
| reg_wr_data | input | 64 | Register write value |
| inv_en | input | 1 | TLB-invalidate operation strobe |
| inv_ric | input | 2 | Invalidate-type field of the operation |
| req_valid | input | 1 | Translation request |
| req_hi | input | 2 | Address bits 63 and 62 of the request |
| req_ready | output | 1 | Block idle, request will be accepted |
| resp_valid | output | 1 | Result present for one cycle |
| resp_fault | output | 1 | Segment fault result |
| resp_root | output | 64 | Root pointer result |
| mem_rd_valid | output | 1 | Entry read request, one cycle |
| mem_rd_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | First doubleword of the entry |
| tlb_flush_d | output | 1 | Data TLB flush request |
| tlb_flush_i | output | 1 | Instruction TLB flush request |

## Verification
The assertions assume the memory side never returns data unless a read is outstanding, and returns exactly one response per read. They also assume that at most one request, write or invalidate strobe is a single-cycle pulse. The bench memory model answers only the read it last saw, after a programmable delay. It drives strobes for one cycle from the falling edge and waits for `req_ready` before presenting a request. The only exception is the deliberate busy-time request that checks R10, which the design must ignore.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_REPLY
    } ptab_state_e;

    localparam int NSLOT    = 2;
    localparam int SLOT_E0  = 0;   // entry 0, upper quadrant
    localparam int SLOT_PID = 1;   // entry at current process ID, lower quadrant

endpackage

// File: rtl/ptab_regs.sv
module ptab_regs
    import ptab_pkg::*;
#(
    parameter int DW      = 64,
    parameter int RIC_W   = 2,
    parameter int RIC_ALL = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [DW-1:0]        wr_data,
    input  logic                 inv_en,
    input  logic [RIC_W-1:0]     inv_ric,
    output logic [DW-1:0]        base_q,
    output logic [DW-1:0]        pid_q,
    output logic [NSLOT-1:0]     clr_vec,
    output logic                 flush_d,
    output logic                 flush_i
);

    logic base_wr, pid_wr, inv_all;
    logic flush_q;

    assign base_wr = wr_en &  wr_sel;
    assign pid_wr  = wr_en & ~wr_sel;
    assign inv_all = inv_en & (inv_ric == RIC_W'(RIC_ALL));

    always_comb begin
        clr_vec           = '0;
        clr_vec[SLOT_E0]  = base_wr | inv_all;
        clr_vec[SLOT_PID] = base_wr | inv_all | pid_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            pid_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            if (base_wr) base_q <= wr_data;
            if (pid_wr)  pid_q  <= wr_data;
            flush_q <= wr_en;
        end
    end

    assign flush_d = flush_q;
    assign flush_i = flush_q;

    a_r9_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flush_d && flush_i));
    a_r9_no_flush_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!flush_d && !flush_i));

endmodule

// File: rtl/ptab_slot.sv
module ptab_slot #(
    parameter int DW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           fill,
    input  logic [DW-1:0]  fill_data,
    output logic           valid,
    output logic [DW-1:0]  root
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            root  <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (fill) begin
            valid <= 1'b1;
            root  <= fill_data;
        end
    end

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !valid);
    a_r4_fill_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !clr) |=> (valid && root == $past(fill_data)));

endmodule

// File: rtl/ptab_fsm.sv
module ptab_fsm
    import ptab_pkg::*;
#(
    parameter int DW  = 64,
    parameter int ESH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_hi,
    output logic                     req_ready,
    input  logic [DW-1:0]            base_q,
    input  logic [DW-1:0]            pid_q,
    input  logic [NSLOT-1:0]         slot_valid,
    input  logic [NSLOT-1:0][DW-1:0] slot_root,
    input  logic [NSLOT-1:0]         slot_clr,
    input  logic                     mem_rsp_valid,
    input  logic [DW-1:0]            mem_rsp_data,
    output logic                     mem_rd_valid,
    output logic [DW-1:0]            mem_rd_addr,
    output logic [NSLOT-1:0]         slot_fill,
    output logic [DW-1:0]            fill_data,
    output logic                     resp_valid,
    output logic                     resp_fault,
    output logic [DW-1:0]            resp_root
);

    ptab_state_e state_q, state_d;
    logic        sel_q, stale_q, fault_q;
    logic [DW-1:0] root_q;

    logic accept, seg_bad, req_sel, hit_now, kill, rsp_ok;

    assign accept  = (state_q == ST_IDLE) & req_valid;
    assign seg_bad = req_hi[1] ^ req_hi[0];
    assign req_sel = req_hi[1] ? 1'(SLOT_E0) : 1'(SLOT_PID);
    assign hit_now = slot_valid[req_sel] & ~slot_clr[req_sel];
    assign kill    = slot_clr[sel_q];
    assign rsp_ok  = mem_rsp_valid & ~(stale_q | kill);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (seg_bad || hit_now) ? ST_REPLY : ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = rsp_ok ? ST_REPLY : ST_ISSUE;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            stale_q <= 1'b0;
            fault_q <= 1'b0;
            root_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                sel_q   <= req_sel;
                fault_q <= seg_bad;
                stale_q <= 1'b0;
                root_q  <= seg_bad ? '0 : slot_root[req_sel];
            end else if (state_q == ST_ISSUE) begin
                if (kill) stale_q <= 1'b1;
            end else if (state_q == ST_WAIT) begin
                if (mem_rsp_valid) begin
                    stale_q <= 1'b0;
                    if (rsp_ok) root_q <= mem_rsp_data;
                end else if (kill) begin
                    stale_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_ISSUE);
        mem_rd_addr  = (sel_q == 1'(SLOT_PID)) ? base_q + (pid_q << ESH) : base_q;
        resp_valid   = (state_q == ST_REPLY);
        resp_fault   = fault_q;
        resp_root    = root_q;
        fill_data    = mem_rsp_data;
        slot_fill    = '0;
        slot_fill[sel_q] = (state_q == ST_WAIT) & rsp_ok;
    end

    a_r2_fault_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seg_bad) |=> (resp_valid && resp_fault && !mem_rd_valid));
    a_r5_hit_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !seg_bad && hit_now) |=>
            (resp_valid && !resp_fault && !mem_rd_valid && resp_root == $past(slot_root[req_sel])));
    a_r4_miss_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !seg_bad && !hit_now) |=> (mem_rd_valid && !resp_valid));
    a_r4_data_replies: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && rsp_ok) |=> (resp_valid && resp_root == $past(mem_rsp_data)));
    a_r11_stale_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid && (stale_q || kill)) |=> (mem_rd_valid && !resp_valid));
    a_r10_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> (!mem_rd_valid && !req_ready));

endmodule

// File: rtl/ptab_root_ctrl.sv
module ptab_root_ctrl
    import ptab_pkg::*;
#(
    parameter int DW      = 64,
    parameter int ESH     = 4,
    parameter int RIC_W   = 2,
    parameter int RIC_ALL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [DW-1:0]    reg_wr_data,
    input  logic             inv_en,
    input  logic [RIC_W-1:0] inv_ric,
    input  logic             req_valid,
    input  logic [1:0]       req_hi,
    output logic             req_ready,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic [DW-1:0]    resp_root,
    output logic             mem_rd_valid,
    output logic [DW-1:0]    mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rsp_data,
    output logic             tlb_flush_d,
    output logic             tlb_flush_i
);

    logic [DW-1:0]            base_q, pid_q, fill_data;
    logic [NSLOT-1:0]         slot_clr, slot_fill, slot_valid;
    logic [NSLOT-1:0][DW-1:0] slot_root;

    ptab_regs #(.DW(DW), .RIC_W(RIC_W), .RIC_ALL(RIC_ALL)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .inv_en  (inv_en),
        .inv_ric (inv_ric),
        .base_q  (base_q),
        .pid_q   (pid_q),
        .clr_vec (slot_clr),
        .flush_d (tlb_flush_d),
        .flush_i (tlb_flush_i)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ptab_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (slot_clr[g]),
            .fill      (slot_fill[g]),
            .fill_data (fill_data),
            .valid     (slot_valid[g]),
            .root      (slot_root[g])
        );
    end

    ptab_fsm #(.DW(DW), .ESH(ESH)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_hi        (req_hi),
        .req_ready     (req_ready),
        .base_q        (base_q),
        .pid_q         (pid_q),
        .slot_valid    (slot_valid),
        .slot_root     (slot_root),
        .slot_clr      (slot_clr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .slot_fill     (slot_fill),
        .fill_data     (fill_data),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_root     (resp_root)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!resp_valid && !mem_rd_valid));

endmodule

// File: tb/ptab_root_ctrl_tb_top.sv
`timescale 1ns/1ps
module ptab_root_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
    logic [63:0] reg_wr_data = '0;
    logic        inv_en = 1'b0;
    logic [1:0]  inv_ric = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_hi = '0;
    logic        req_ready, resp_valid, resp_fault;
    logic [63:0] resp_root, mem_rd_addr;
    logic        mem_rd_valid;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        tlb_flush_d, tlb_flush_i;

    always #4 clk = ~clk;   // 125 MHz

    ptab_root_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .inv_en(inv_en), .inv_ric(inv_ric),
        .req_valid(req_valid), .req_hi(req_hi), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_root(resp_root),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .tlb_flush_d(tlb_flush_d), .tlb_flush_i(tlb_flush_i)
    );

    typedef struct {
        bit          fault;
        logic [63:0] root;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] rd_exp_q[$];
    int          n_chk = 0, n_err = 0;
    int          rd_count = 0, mem_lat = 1, mem_cnt = 0;
    logic [63:0] mem_addr_q = '0;
    bit          done = 1'b0;

    function automatic logic [63:0] mix(input logic [63:0] a);
        return a ^ 64'h5A5A_3C3C_0000_F00D;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // memory model: one outstanding read, response after mem_lat cycles
    always @(negedge clk) begin
        logic [63:0] ea;
        mem_rsp_valid = 1'b0;
        if (mem_cnt > 0) begin
            mem_cnt--;
            if (mem_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mix(mem_addr_q);
            end
        end
        if (rst_n && mem_rd_valid) begin
            rd_count++;
            if (rd_exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected read", mem_rd_addr, '0);
            end else begin
                ea = rd_exp_q.pop_front();
                check(mem_rd_addr == ea, "R3 R4", "read address", mem_rd_addr, ea);
            end
            mem_addr_q = mem_rd_addr;
            mem_cnt    = mem_lat;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", resp_root, '0);
            end else begin
                e = exp_q.pop_front();
                check(resp_fault == e.fault, e.tag, "fault", 64'(resp_fault), 64'(e.fault));
                check(resp_root == e.root, e.tag, "root", resp_root, e.root);
            end
        end
    end

    task automatic wr_reg(input bit sel, input logic [63:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(tlb_flush_d && tlb_flush_i, "R9", "flush after write",
              {62'b0, tlb_flush_d, tlb_flush_i}, 64'd3);
        @(negedge clk);
        check(!tlb_flush_d && !tlb_flush_i, "R9", "flush one cycle",
              {62'b0, tlb_flush_d, tlb_flush_i}, 64'd0);
    endtask

    task automatic do_inv(input logic [1:0] ric);
        @(negedge clk);
        inv_en = 1'b1; inv_ric = ric;
        @(negedge clk);
        inv_en = 1'b0;
        check(!tlb_flush_d && !tlb_flush_i, "R9", "no flush on invalidate",
              {62'b0, tlb_flush_d, tlb_flush_i}, 64'd0);
    endtask

    task automatic do_req(input logic [1:0] hi, input bit fault, input logic [63:0] root,
                          input int nrd, input string tag);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_hi = hi;
        exp_q.push_back('{fault, root, tag});
        r0 = rd_count;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        check(rd_count - r0 == nrd, tag, "read count", 64'(rd_count - r0), 64'(nrd));
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                check(1'b0, "R10", "watchdog expired", 64'(cyc), '0);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    localparam logic [63:0] B1 = 64'h0000_0000_0010_0000;
    localparam logic [63:0] B2 = 64'h0000_0000_0020_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
        check(!resp_valid && !mem_rd_valid, "R1", "quiet after reset",
              {62'b0, resp_valid, mem_rd_valid}, 64'd0);
        check(!tlb_flush_d && !tlb_flush_i, "R1", "no flush after reset",
              {62'b0, tlb_flush_d, tlb_flush_i}, 64'd0);

        wr_reg(1'b1, B1);
        wr_reg(1'b0, 64'd3);

        // R1 R3 R4: empty slots miss, each quadrant at its own address
        rd_exp_q.push_back(B1);
        do_req(2'b11, 1'b0, mix(B1), 1, "R1 R3 R4 upper miss");
        do_req(2'b11, 1'b0, mix(B1), 0, "R5 upper hit");
        rd_exp_q.push_back(B1 + 64'h30);
        do_req(2'b00, 1'b0, mix(B1 + 64'h30), 1, "R3 R4 lower miss");
        do_req(2'b00, 1'b0, mix(B1 + 64'h30), 0, "R5 lower hit");

        // R2 segment faults
        do_req(2'b10, 1'b1, '0, 0, "R2 fault 10");
        do_req(2'b01, 1'b1, '0, 0, "R2 fault 01");

        // R8 other invalidate types have no effect
        do_inv(2'd0); do_inv(2'd1); do_inv(2'd3);
        do_req(2'b11, 1'b0, mix(B1), 0, "R8 upper kept");
        do_req(2'b00, 1'b0, mix(B1 + 64'h30), 0, "R8 lower kept");

        // R7 process ID write drops only the lower slot
        wr_reg(1'b0, 64'd5);
        do_req(2'b11, 1'b0, mix(B1), 0, "R7 upper kept");
        rd_exp_q.push_back(B1 + 64'h50);
        do_req(2'b00, 1'b0, mix(B1 + 64'h50), 1, "R7 lower refetch");

        // R8 invalidate type 2 drops both
        do_inv(2'd2);
        rd_exp_q.push_back(B1);
        do_req(2'b11, 1'b0, mix(B1), 1, "R8 upper dropped");
        rd_exp_q.push_back(B1 + 64'h50);
        do_req(2'b00, 1'b0, mix(B1 + 64'h50), 1, "R8 lower dropped");

        // R6 base write drops both and moves the table
        wr_reg(1'b1, B2);
        rd_exp_q.push_back(B2);
        do_req(2'b11, 1'b0, mix(B2), 1, "R6 upper dropped");
        rd_exp_q.push_back(B2 + 64'h50);
        do_req(2'b00, 1'b0, mix(B2 + 64'h50), 1, "R6 lower dropped");

        // R10 R11 invalidation during a fetch, request while busy ignored
        wr_reg(1'b0, 64'd6);
        mem_lat = 8;
        rd_exp_q.push_back(B2 + 64'h60);
        rd_exp_q.push_back(B2 + 64'h90);
        fork
            do_req(2'b00, 1'b0, mix(B2 + 64'h90), 2, "R11 stale refetch");
            begin
                repeat (3) @(negedge clk);
                check(!req_ready, "R10", "busy while fetching", 64'(req_ready), 64'd0);
                req_valid = 1'b1; req_hi = 2'b10;
                @(negedge clk);
                req_valid = 1'b0;
                wr_reg(1'b0, 64'd9);
            end
        join
        mem_lat = 1;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "no extra response", 64'(exp_q.size()), 64'd0);
        do_req(2'b00, 1'b0, mix(B2 + 64'h90), 0, "R11 refetched entry kept");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule